// File: doc/BRIEF.md
# Length-Framed Packet Multiplexer

This block merges payload streams from several source FIFOs into one framed word stream. It picks one non-empty source and stays with it until that source's end-of-data marker. While it reads, it stores the 16-bit payload words in an internal buffer and counts them. It then sends a two-word header followed by the stored payload. The first header word holds the source index and the second holds the payload length in bytes. The length is always taken from the words the block itself collected.

Each source FIFO entry holds a data word and a marker bit. An entry whose marker bit is set closes the packet and carries no payload. A source that has nothing to report for a time slice pushes only a marker. The block then sends a packet with a header and no payload, so the receiver learns that the slice is complete without waiting on a timeout. All sources have equal priority under a rotating pointer, so a source may wait while another is served. The output side uses a valid/ready handshake.

Top module: `pkt_len_mux`

## Requirements
- R1: A source's pop strobe is raised only while that source's empty flag is low, and at most one pop strobe is high in any cycle.
- R2: Once a source is granted, no other source is popped and no output word is offered until the granted source delivers an entry with its marker bit (bit 16 of the FIFO entry) set, however long that takes.
- R3: Grants rotate. After reset the search starts at source 0. After a packet from source g has been fully sent, the search starts at source g+1 (wrapping to 0), and the first non-empty source found from there is granted.
- R4: A FIFO entry with the marker bit set ends the packet and adds no payload word. A packet made of only a marker is sent as a header with length 0 and no payload.
- R5: The first word of every packet carries the source index, zero-extended to 16 bits, with start-of-packet set. The second word carries the byte length, which is twice the number of payload words kept. End-of-packet is set on the second word only when no payload follows.
- R6: Payload words follow the header in the order they were popped, and end-of-packet is set on the last one.
- R7: At most BUF_DEPTH payload words are kept per packet. Words beyond that are popped and dropped, and the overflow flag is set. The flag stays set until reset. A packet of exactly BUF_DEPTH words does not set the flag.
- R8: While an output word is offered and ready is low, the word and its start/end flags are held unchanged.
- R9: After reset the block offers no output word, pops no source and shows the overflow flag clear.
- R10: A new source is not read until every word of the previous packet has been accepted at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_empty | input | N_CH | Empty flag per source FIFO |
| src_word | input | 16*N_CH | Head-of-FIFO data word per source, source c at bits 16c+15:16c |
| src_last | input | N_CH | Marker bit of the head entry per source |
| src_pop | output | N_CH | Pop strobe per source, takes the head entry at the clock edge |
| pkt_data | output | 16 | Output word |
| pkt_valid | output | 1 | Output word is valid |
| pkt_sop | output | 1 | Output word is the first of a packet |
| pkt_eop | output | 1 | Output word is the last of a packet |
| pkt_ready | input | 1 | Downstream accepts the offered word |
| trunc_flag | output | 1 | Sticky overflow flag, set when a packet exceeded the buffer |

## Verification
Two events can fall in the same cycle. One is the buffer reaching its limit and the end marker arriving at once, which must close the packet without setting the overflow flag. The other is a wait for a marker on the locked source while another source is already waiting to be served. A sweep over every packet length from zero to two past the buffer depth, on all three sources in one round, produces the first event at length equal to the depth. That sweep checks the flag after each round. A held-back marker on one source with a full FIFO on another produces the second event. The bench checks that the waiting source is never popped and that no word is offered until the marker is pushed. Downstream ready toggles in a pseudo-random pattern during half of the sweep, and the expected stream is rebuilt arithmetically from the lengths and the rotation order.

// File: rtl/pmux_pkg.sv
// Package: shared word width and controller states for the packet multiplexer.
// Assumes: payload and header words are 16 bits wide.
package pmux_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HDR_ID,
        ST_HDR_LEN,
        ST_PAYLOAD
    } pmux_state_e;
endpackage

// File: rtl/pmux_rr_arb.sv
// Module: pmux_rr_arb
// Combinational rotating-priority picker. Starting at index ptr and
// wrapping, it returns the first source whose request is high.
// Assumes: ptr < N_CH.
module pmux_rr_arb #(
    parameter int N_CH  = 2,
    parameter int IDX_W = 1
) (
    input  logic [N_CH-1:0]  req,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);
    // Scan offsets from highest to lowest so the nearest requester wins.
    always_comb begin
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = N_CH - 1; k >= 0; k--) begin
            int cand;
            cand = int'(ptr) + k;
            if (cand >= N_CH) cand = cand - N_CH;
            if (req[cand]) begin
                gnt_idx = IDX_W'(cand);
                gnt_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmux_pkt_buf.sv
// Module: pmux_pkt_buf
// Register-array payload store with one write port and an asynchronous
// read port. Holds the payload of one packet while its length is counted.
// Assumes: the writer never addresses beyond BUF_DEPTH-1.
module pmux_pkt_buf
    import pmux_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [BUF_DEPTH];

    // Store a payload word when the controller asks.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the addressed word to the output path.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pkt_len_mux.sv
// Module: pkt_len_mux (top)
// Merges N_CH source FIFOs into framed packets: [source id][byte length]
// [payload...]. A granted source is read until its marker entry, with the
// payload buffered so the header length is exact. Grants rotate.
// Assumes: source FIFOs are show-ahead (head entry visible while not empty,
// removed at the clock edge where src_pop is high).
module pkt_len_mux
    import pmux_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int BUF_DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        src_empty,
    input  logic [N_CH*WORD_W-1:0] src_word,
    input  logic [N_CH-1:0]        src_last,
    output logic [N_CH-1:0]        src_pop,
    output logic [WORD_W-1:0]      pkt_data,
    output logic                   pkt_valid,
    output logic                   pkt_sop,
    output logic                   pkt_eop,
    input  logic                   pkt_ready,
    output logic                   trunc_flag
);
    localparam int IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
    localparam int ADDR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

    pmux_state_e       state;
    logic [IDX_W-1:0]  gnt;
    logic [IDX_W-1:0]  rr_ptr;
    logic [IDX_W-1:0]  gnt_next;
    logic [CNT_W-1:0]  wcount;
    logic [CNT_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  arb_idx;
    logic              arb_any;
    logic              sel_empty;
    logic              sel_last;
    logic [WORD_W-1:0] sel_word;
    logic              pop_now;
    logic              buf_full;
    logic              buf_wr;
    logic [WORD_W-1:0] buf_rd;
    logic              last_pay;
    logic [CNT_W:0]    len_bytes;

    pmux_rr_arb #(.N_CH(N_CH), .IDX_W(IDX_W)) i_arb (
        .req     (~src_empty),
        .ptr     (rr_ptr),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    pmux_pkt_buf #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) i_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_addr (wcount[ADDR_W-1:0]),
        .wr_data (sel_word),
        .rd_addr (rd_idx[ADDR_W-1:0]),
        .rd_data (buf_rd)
    );

    // Head entry of the granted source.
    assign sel_empty = src_empty[gnt];
    assign sel_last  = src_last[gnt];
    assign sel_word  = src_word[gnt*WORD_W +: WORD_W];

    // Pop whenever collecting and the granted source has an entry.
    assign pop_now  = (state == ST_COLLECT) && !sel_empty;
    assign buf_full = (wcount == CNT_W'(BUF_DEPTH));
    assign buf_wr   = pop_now && !sel_last && !buf_full;

    // Per-source pop strobe, only for the granted index.
    for (genvar c = 0; c < N_CH; c++) begin : g_pop
        assign src_pop[c] = pop_now && (gnt == IDX_W'(c));
    end

    assign gnt_next  = (gnt == IDX_W'(N_CH - 1)) ? '0 : gnt + 1'b1;
    assign last_pay  = (rd_idx == wcount - 1'b1);
    assign len_bytes = {wcount, 1'b0};

    // Controller: grant, collect, send header, send payload, rotate pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gnt        <= '0;
            rr_ptr     <= '0;
            wcount     <= '0;
            rd_idx     <= '0;
            trunc_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        gnt    <= arb_idx;
                        wcount <= '0;
                        state  <= ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (pop_now) begin
                        if (sel_last)       state      <= ST_HDR_ID;
                        else if (!buf_full) wcount     <= wcount + 1'b1;
                        else                trunc_flag <= 1'b1;
                    end
                end
                ST_HDR_ID: begin
                    if (pkt_ready) state <= ST_HDR_LEN;
                end
                ST_HDR_LEN: begin
                    if (pkt_ready) begin
                        rd_idx <= '0;
                        if (wcount == '0) begin
                            rr_ptr <= gnt_next;
                            state  <= ST_IDLE;
                        end else begin
                            state  <= ST_PAYLOAD;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    if (pkt_ready) begin
                        if (last_pay) begin
                            rr_ptr <= gnt_next;
                            state  <= ST_IDLE;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output word and framing flags from the current state.
    always_comb begin
        pkt_data  = '0;
        pkt_valid = 1'b0;
        pkt_sop   = 1'b0;
        pkt_eop   = 1'b0;
        case (state)
            ST_HDR_ID: begin
                pkt_data  = WORD_W'(gnt);
                pkt_valid = 1'b1;
                pkt_sop   = 1'b1;
            end
            ST_HDR_LEN: begin
                pkt_data  = WORD_W'(len_bytes);
                pkt_valid = 1'b1;
                pkt_eop   = (wcount == '0);
            end
            ST_PAYLOAD: begin
                pkt_data  = buf_rd;
                pkt_valid = 1'b1;
                pkt_eop   = last_pay;
            end
            default: ;
        endcase
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) (src_pop & src_empty) == '0) else $error("pop of empty source"); // R1
    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src_pop)) else $error("multiple pops"); // R1
    AST_LOCKED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (|src_pop && !(|(src_pop & src_last))) |=> $stable(gnt) && !pkt_valid) else $error("lock broken"); // R2
    AST_NO_POP_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n) pkt_valid |-> src_pop == '0) else $error("pop during send"); // R10
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_data) && $stable(pkt_sop) && $stable(pkt_eop)) else $error("stall not held"); // R8
    AST_TRUNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) trunc_flag |=> trunc_flag) else $error("flag cleared"); // R7
    AST_SOP_HEADER: assert property (@(posedge clk) disable iff (!rst_n) pkt_sop |-> pkt_valid && !pkt_eop) else $error("bad sop"); // R5
endmodule

// File: tb/test_pkt_len_mux.sv
// Bench for pkt_len_mux with three sources and a four-word buffer.
module test_pkt_len_mux;
    localparam int NC    = 3;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   src_empty;
    logic [NC*16-1:0] src_word;
    logic [NC-1:0]   src_last;
    logic [NC-1:0]   src_pop;
    logic [15:0]     pkt_data;
    logic            pkt_valid, pkt_sop, pkt_eop;
    logic            pkt_ready = 1'b0;
    logic            trunc_flag;

    always #2.5 clk = ~clk;

    pkt_len_mux #(.N_CH(NC), .BUF_DEPTH(DEPTH)) i_pkt_len_mux (
        .clk(clk), .rst_n(rst_n), .src_empty(src_empty), .src_word(src_word),
        .src_last(src_last), .src_pop(src_pop), .pkt_data(pkt_data),
        .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
        .pkt_ready(pkt_ready), .trunc_flag(trunc_flag)
    );

    // Source FIFO models: entry = {marker, word}.
    logic [16:0] fmem [NC][64];
    logic [5:0]  fwr [NC];
    logic [5:0]  frd [NC];

    for (genvar c = 0; c < NC; c++) begin : g_src
        assign src_empty[c]          = (fwr[c] == frd[c]);
        assign src_word[c*16 +: 16]  = fmem[c][frd[c]][15:0];
        assign src_last[c]           = fmem[c][frd[c]][16];
        always @(posedge clk) begin
            if (!rst_n) frd[c] <= '0;
            else if (src_pop[c]) frd[c] <= frd[c] + 1'b1;
        end
    end

    // Expected output stream: {sop, eop, data}.
    logic [17:0] exp_q [1024];
    int exp_wr = 0;
    int rx_idx = 0;
    int mon_checks = 0, mon_fail = 0;
    int n_checks = 0, n_fail = 0;
    logic stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    // Drive ready, then record the word that the next edge will take.
    always @(negedge clk) begin
        if (!rst_n) begin
            pkt_ready = 1'b0;
        end else begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pkt_ready = stall_mode ? lfsr[0] : 1'b1;
            if (pkt_valid && pkt_ready) begin
                mon_checks++;
                if (rx_idx >= exp_wr) begin
                    mon_fail++;
                    $display("FAIL R6 unexpected word %0d: got %h, expected none", rx_idx, pkt_data);
                end else if ({pkt_sop, pkt_eop, pkt_data} != exp_q[rx_idx]) begin
                    mon_fail++;
                    $display("FAIL R5/R6 word %0d: got sop=%b eop=%b data=%h, expected %h",
                             rx_idx, pkt_sop, pkt_eop, pkt_data, exp_q[rx_idx]);
                end
                rx_idx++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d, expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_entry(input int c, input logic [15:0] w, input logic mk);
        fmem[c][fwr[c]] = {mk, w};
        fwr[c] = fwr[c] + 1'b1;
    endtask

    task automatic load_pkt(input int c, input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) push_entry(c, base + 16'(i), 1'b0);
        push_entry(c, 16'h0, 1'b1);
    endtask

    task automatic expect_pkt(input int c, input int n, input logic [15:0] base);
        int kept;
        kept = (n > DEPTH) ? DEPTH : n;
        exp_q[exp_wr] = {1'b1, 1'b0, 16'(c)}; exp_wr++;
        exp_q[exp_wr] = {1'b0, kept == 0, 16'(kept * 2)}; exp_wr++;
        for (int i = 0; i < kept; i++) begin
            exp_q[exp_wr] = {1'b0, i == kept - 1, base + 16'(i)};
            exp_wr++;
        end
    endtask

    task automatic drain(input string tag);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (rx_idx == exp_wr && (&src_empty)) break;
        end
        repeat (4) @(negedge clk);
        check(rx_idx == exp_wr, tag, rx_idx, exp_wr);
    endtask

    function automatic logic [15:0] pbase(input int c, input int n);
        return 16'h1000 * 16'(c + 1) + 16'(n * 16);
    endfunction

    initial begin
        for (int c = 0; c < NC; c++) begin
            fwr[c] = '0;
            for (int i = 0; i < 64; i++) fmem[c][i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(pkt_valid == 1'b0, "R9 valid after reset", int'(pkt_valid), 0);
        check(src_pop == '0, "R9 pop after reset", int'(src_pop), 0);
        check(trunc_flag == 1'b0, "R9 flag after reset", int'(trunc_flag), 0);

        // R3/R4/R5/R6/R7: sweep lengths 0..DEPTH with ready high
        for (int n = 0; n <= DEPTH; n++) begin
            for (int c = 0; c < NC; c++) load_pkt(c, n, pbase(c, n));
            for (int c = 0; c < NC; c++) expect_pkt(c, n, pbase(c, n));
            drain("R4 R6 stream length (ready high)");
            check(trunc_flag == 1'b0, "R7 no flag at or below depth", int'(trunc_flag), 0);
        end

        // R8 plus R7 overflow: sweep 0..DEPTH+2 under random stalls
        stall_mode = 1'b1;
        for (int n = 0; n <= DEPTH + 2; n++) begin
            for (int c = 0; c < NC; c++) load_pkt(c, n, pbase(c, n));
            for (int c = 0; c < NC; c++) expect_pkt(c, n, pbase(c, n));
            drain("R8 stream under stalls");
            check(trunc_flag == (n > DEPTH), "R7 overflow flag", int'(trunc_flag), int'(n > DEPTH));
        end
        stall_mode = 1'b0;

        // R3: rotation, pointer at 0; source 0 has two packets, source 2 one
        load_pkt(0, 2, 16'h0a00);
        load_pkt(0, 3, 16'h0b00);
        load_pkt(2, 1, 16'h0c00);
        expect_pkt(0, 2, 16'h0a00);
        expect_pkt(2, 1, 16'h0c00);
        expect_pkt(0, 3, 16'h0b00);
        drain("R3 rotation order");

        // R2: source 1 locked without marker, source 2 waits
        push_entry(1, 16'h0d00, 1'b0);
        push_entry(1, 16'h0d01, 1'b0);
        load_pkt(2, 2, 16'h0e00);
        begin
            int rx0;
            rx0 = rx_idx;
            repeat (30) @(negedge clk);
            check(rx_idx == rx0, "R2 no output before marker", rx_idx, rx0);
            check(fwr[2] - frd[2] == 6'd3, "R2 waiting source not popped", int'(fwr[2] - frd[2]), 3);
            check(src_empty[1] == 1'b1, "R2 locked source drained", int'(src_empty[1]), 1);
        end
        push_entry(1, 16'h0, 1'b1);
        expect_pkt(1, 2, 16'h0d00);
        expect_pkt(2, 2, 16'h0e00);
        drain("R2 R10 locked packet then next");
        check(trunc_flag == 1'b1, "R7 flag stays set", int'(trunc_flag), 1);

        $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks, n_fail + mon_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fail + mon_fail + 1);
        $finish;
    end
endmodule